// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block runs a series of analog-to-digital conversions. A sequence begins on a software start command or on an external trigger pin. For each conversion it sends a one-cycle start strobe and a channel index to the converter, then waits for the converter's done strobe. It steps the channel index from 0 up to the configured length minus one. When the last conversion of the sequence finishes, it sets a completion flag, which can also raise an interrupt.

Software uses a small register port. The configuration register sets the sequence length, the interrupt enable, the trigger enable and the trigger sensitivity. The status register reports busy, completion and interrupt state and the current channel. Writing the status register carries the start and flag-clear commands. Any write to the configuration register cancels the sequence in progress and does not start a new one.

The converter side is plain strobes. It has no valid/ready handshake, because no data stream passes through the block: results are stored elsewhere.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the configuration register (address 0) reads 0x04: length field 4, interrupt enable off, trigger off. The status register (address 1) reads 0x00, `conv_start` and `irq` are low, and `conv_chan` is 0.
- R2: The length field is configuration bits [3:0]. Value 0 and values above 8 give 8 conversions, and values 1 to 8 give that many. A sequence issues exactly that many `conv_start` strobes and no more.
- R3: The first `conv_start` carries `conv_chan` 0. After each done strobe that is not the last, the index rises by one and the next `conv_start` comes in the following cycle.
- R4: In the cycle after the last done strobe, status bit 1 (complete) reads 1 and status bit 0 (busy) reads 0.
- R5: Writing status with bit 1 set clears the complete flag. Starting a new sequence also clears it.
- R6: Any write to address 0 ends a running sequence at once. Busy drops, no further `conv_start` is issued even when done strobes arrive, and the complete flag is not set.
- R7: Writing status bit 0 = 1 starts a sequence when idle. A start request, whether from software or the trigger, is ignored while a sequence runs, and the channel index is kept.
- R8: Configuration bit 7 enables the trigger input and bits [6:5] pick its sensitivity: 00 falling edge, 01 rising edge, 10 low level, 11 high level. The input passes through a two-flop synchroniser. In level mode a new sequence starts whenever the active level is present while idle. With bit 7 clear the trigger pin is ignored.
- R9: Status bit 2 (interrupt flag) equals the complete flag when configuration bit 4 is set and reads 0 otherwise. `irq` equals that bit. Writing status bit 2 has no effect.
- R10: A done strobe while idle has no effect: no `conv_start`, the index stays 0 and the flag stays clear.
- R11: If the last done strobe and a flag-clear write fall in the same cycle, the complete flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 config, 1 status/command) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ext_trig | input | 1 | Asynchronous external trigger |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_chan | output | 3 | Channel index of the current conversion |
| conv_done | input | 1 | One-cycle conversion-done strobe from the converter |
| irq | output | 1 | Sequence-complete interrupt request |

## Verification
The last done strobe of a sequence can land in the same cycle as a software write that clears the complete flag. The bench provokes this by driving `conv_done` and the clear write on the same clock edge. It judges the result by reading status afterwards, which must show the flag set. The same kind of collision between a done strobe and a configuration write is also covered: there the abort must win, and no further start strobe or flag may appear.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    TRG_FALL = 2'b00,
    TRG_RISE = 2'b01,
    TRG_LOW  = 2'b10,
    TRG_HIGH = 2'b11
  } trig_mode_e;

  localparam int CFG_LEN_W = 4;

  typedef struct packed {
    logic                 trig_en;
    trig_mode_e           mode;
    logic                 irq_en;
    logic [CFG_LEN_W-1:0] len;
  } seq_cfg_t;

  localparam seq_cfg_t CFG_RESET = '{trig_en: 1'b0, mode: TRG_FALL,
                                     irq_en: 1'b0, len: 4'd4};

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_trig,
  input  logic       trig_en,
  input  trig_mode_e mode,
  output logic       trig_hit
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_trig};
      prev_q <= cur;
    end
  end

  always_comb begin
    unique case (mode)
      TRG_FALL: trig_hit = ~cur & prev_q;
      TRG_RISE: trig_hit = cur & ~prev_q;
      TRG_LOW:  trig_hit = ~cur;
      default:  trig_hit = cur;
    endcase
    trig_hit = trig_hit & trig_en;
  end

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core #(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8,
  parameter int CHAN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  len_field,
  input  logic              start_req,
  input  logic              abort,
  input  logic              clr_cplt,
  input  logic              conv_done,
  output logic              busy,
  output logic              cplt,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  output logic [CHAN_W-1:0] last_idx
);

  logic start_go;
  logic done_ok;
  logic final_done;

  always_comb begin
    if (len_field == '0 || int'(len_field) > MAX_LEN)
      last_idx = CHAN_W'(MAX_LEN - 1);
    else
      last_idx = CHAN_W'(int'(len_field) - 1);
  end

  assign start_go   = start_req & ~busy & ~abort;
  assign done_ok    = conv_done & busy & ~abort;
  assign final_done = done_ok & (conv_chan == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      conv_start <= 1'b0;
      if (abort) begin
        busy      <= 1'b0;
        conv_chan <= '0;
      end else if (start_go) begin
        busy       <= 1'b1;
        conv_chan  <= '0;
        conv_start <= 1'b1;
      end else if (done_ok) begin
        if (final_done) begin
          busy      <= 1'b0;
          conv_chan <= '0;
        end else begin
          conv_chan  <= conv_chan + 1'b1;
          conv_start <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cplt <= 1'b0;
    else if (final_done)            cplt <= 1'b1;
    else if (start_go || clr_cplt)  cplt <= 1'b0;
  end

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              busy,
  input  logic              cplt,
  input  logic [CHAN_W-1:0] chan,
  output seq_cfg_t          cfg,
  output logic              cfg_wr,
  output logic              sw_start,
  output logic              clr_cplt,
  output logic              irq_flag,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;

  assign cfg_wr   = reg_wr && reg_addr == ADDR_CFG;
  assign sw_start = reg_wr && reg_addr == ADDR_STAT && reg_wdata[0];
  assign clr_cplt = reg_wr && reg_addr == ADDR_STAT && reg_wdata[1];
  assign irq_flag = cfg.irq_en & cplt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= CFG_RESET;
    else if (cfg_wr) cfg <= seq_cfg_t'(reg_wdata[$bits(seq_cfg_t)-1:0]);
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CFG: reg_rdata[$bits(seq_cfg_t)-1:0] = cfg;
      ADDR_STAT: begin
        reg_rdata[0]          = busy;
        reg_rdata[1]          = cplt;
        reg_rdata[2]          = irq_flag;
        reg_rdata[4 +: CHAN_W] = chan;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MAX_LEN     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CHAN_W     = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_trig,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_done,
  output logic              irq
);

  seq_cfg_t          cfg;
  logic              cfg_wr;
  logic              sw_start;
  logic              clr_cplt;
  logic              trig_hit;
  logic              seq_busy;
  logic              seq_cplt;
  logic              irq_flag;
  logic [CHAN_W-1:0] last_idx;

  adc_seq_regs #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .busy(seq_busy), .cplt(seq_cplt), .chan(conv_chan),
    .cfg, .cfg_wr, .sw_start, .clr_cplt, .irq_flag, .reg_rdata
  );

  adc_seq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk, .rst_n, .ext_trig, .trig_en(cfg.trig_en), .mode(cfg.mode), .trig_hit
  );

  adc_seq_core #(.LEN_W(CFG_LEN_W), .MAX_LEN(MAX_LEN), .CHAN_W(CHAN_W)) u_core (
    .clk, .rst_n, .len_field(cfg.len), .start_req(sw_start | trig_hit),
    .abort(cfg_wr), .clr_cplt, .conv_done,
    .busy(seq_busy), .cplt(seq_cplt), .conv_start, .conv_chan, .last_idx
  );

  assign irq = irq_flag;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              busy,
  input logic              cplt,
  input logic              irq_en,
  input logic              irq,
  input logic              conv_start,
  input logic              conv_done,
  input logic [CHAN_W-1:0] conv_chan,
  input logic [CHAN_W-1:0] last_idx
);

  a_r6_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!busy && !conv_start));

  a_r7_start_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  a_r3_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_done && !cfg_wr && conv_chan != last_idx)
      |=> (conv_start && conv_chan == ($past(conv_chan) + 1'b1)));

  a_r4_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cplt) |-> ($past(conv_done) && $past(busy) && !busy));

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cplt && irq_en));

  a_r10_idle_chan: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (conv_chan == '0));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .busy(seq_busy), .cplt(seq_cplt),
  .irq_en(cfg.irq_en), .irq(irq), .conv_start(conv_start), .conv_done(conv_done),
  .conv_chan(conv_chan), .last_idx(last_idx)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       ext_trig = 1'b0;
  logic       conv_start;
  logic [2:0] conv_chan;
  logic       conv_done = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .ext_trig, .conv_start, .conv_chan, .conv_done, .irq
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // high nibble: length field, low nibble: expected conversion count
  localparam logic [7:0] VEC [7] = '{8'h11, 8'h22, 8'h44, 8'h77, 8'h88, 8'h08, 8'hC8};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic done_pulse();
    conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
  endtask

  task automatic wait_start(input int lim, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < lim; k++) begin
      if (conv_start) begin
        seen = 1'b1;
        break;
      end
      tick();
    end
  endtask

  task automatic count_starts(input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      if (conv_start) cnt++;
      tick();
    end
  endtask

  initial begin
    logic [7:0] d;
    bit seen;
    int cnt;

    repeat (3) tick();
    // R1 reset state
    rd(2'd0, d); chk(d == 8'h04, "R1 cfg reset", d, 4);
    rd(2'd1, d); chk(d == 8'h00, "R1 status reset", d, 0);
    chk(!conv_start && !irq && conv_chan == 0, "R1 outputs reset", {conv_start, irq}, 0);
    rst_n = 1'b1;
    tick();

    // R2 R3 R4 R5 table of lengths
    for (int v = 0; v < 7; v++) begin
      int n;
      n = int'(VEC[v][3:0]);
      wr(2'd0, {4'b0001, VEC[v][7:4]});
      wr(2'd1, 8'h01);
      for (int i = 0; i < n; i++) begin
        chk(conv_start == 1'b1, "R3 start strobe timing", conv_start, 1);
        chk(conv_chan == 3'(i), "R3 channel index", conv_chan, i);
        done_pulse();
      end
      rd(2'd1, d);
      chk(d[1] == 1'b1, "R4 complete set", d[1], 1);
      chk(d[0] == 1'b0, "R4 busy clear", d[0], 0);
      chk(irq == 1'b1, "R9 irq with enable", irq, 1);
      count_starts(5, cnt);
      chk(cnt == 0, "R2 no extra starts", cnt, 0);
      wr(2'd1, 8'h02);
      rd(2'd1, d); chk(d[1] == 1'b0, "R5 write-one clear", d[1], 0);
    end

    // R5 new start clears flag
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h01); done_pulse();
    rd(2'd1, d); chk(d[1] == 1'b1, "R5 flag before restart", d[1], 1);
    wr(2'd1, 8'h01);
    rd(2'd1, d); chk(d[1] == 1'b0 && d[0] == 1'b1, "R5 start clears flag", d, 1);
    done_pulse(); wr(2'd1, 8'h02);

    // R6 abort, including done colliding with config write
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h01); done_pulse();
    conv_done = 1'b1;
    wr(2'd0, 8'h04);
    conv_done = 1'b0;
    rd(2'd1, d); chk(d[0] == 1'b0, "R6 abort busy", d[0], 0);
    for (int k = 0; k < 4; k++) done_pulse();
    count_starts(4, cnt);
    chk(cnt == 0 && !conv_start, "R6 no start after abort", cnt, 0);
    rd(2'd1, d); chk(d[1] == 1'b0, "R6 no flag after abort", d[1], 0);

    // R7 start while busy ignored
    wr(2'd1, 8'h01); done_pulse();
    wr(2'd1, 8'h01);
    chk(conv_chan == 3'd1, "R7 chan kept on extra start", conv_chan, 1);
    chk(!conv_start, "R7 no restart strobe", conv_start, 0);
    done_pulse(); done_pulse(); done_pulse();
    rd(2'd1, d); chk(d[1] == 1'b1, "R7 sequence finishes", d[1], 1);
    wr(2'd1, 8'h02);

    // R10 done while idle
    done_pulse(); done_pulse();
    rd(2'd1, d);
    chk(d == 8'h00 && !conv_start, "R10 idle done ignored", d, 0);

    // R11 last done and clear write in same cycle
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h01); done_pulse();
    conv_done = 1'b1;
    wr(2'd1, 8'h02);
    conv_done = 1'b0;
    rd(2'd1, d); chk(d[1] == 1'b1, "R11 set beats clear", d[1], 1);
    wr(2'd1, 8'h02);

    // R9 interrupt flag gating and read-only bit
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h01); done_pulse();
    rd(2'd1, d);
    chk(d[2] == 1'b0 && !irq && d[1], "R9 disabled reads zero", d, 2);
    wr(2'd0, 8'h11);
    rd(2'd1, d); chk(d[2] == 1'b1 && irq, "R9 enabled mirrors", d, 6);
    wr(2'd1, 8'h04);
    rd(2'd1, d); chk(d[1] && d[2], "R9 write bit2 no effect set", d, 6);
    wr(2'd1, 8'h02);
    wr(2'd1, 8'h04);
    rd(2'd1, d); chk(d[2] == 1'b0 && !irq, "R9 write bit2 no effect clear", d, 0);

    // R8 trigger disabled
    wr(2'd0, 8'h21);
    ext_trig = 1'b1; count_starts(6, cnt);
    ext_trig = 1'b0; count_starts(6, cnt);
    chk(cnt == 0, "R8 trigger disabled", cnt, 0);
    // rising edge
    wr(2'd0, 8'hA1);
    ext_trig = 1'b1; wait_start(8, seen);
    chk(seen, "R8 rising edge starts", seen, 1);
    done_pulse();
    count_starts(8, cnt); chk(cnt == 0, "R8 edge no retrigger", cnt, 0);
    // falling edge
    wr(2'd0, 8'h81);
    ext_trig = 1'b0; wait_start(8, seen);
    chk(seen, "R8 falling edge starts", seen, 1);
    done_pulse();
    // high level
    wr(2'd0, 8'hE1);
    count_starts(6, cnt); chk(cnt == 0, "R8 high level idle", cnt, 0);
    ext_trig = 1'b1; wait_start(8, seen);
    chk(seen, "R8 high level starts", seen, 1);
    done_pulse();
    wait_start(4, seen); chk(seen, "R8 level restarts", seen, 1);
    ext_trig = 1'b0; repeat (4) tick();
    wr(2'd0, 8'h01);
    // low level
    wr(2'd0, 8'hC1);
    wait_start(8, seen); chk(seen, "R8 low level starts", seen, 1);
    wr(2'd0, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule